// File: doc/BRIEF.md
# Node Fan-out Balance Checker

This block sits beside an arithmetic-graph evaluator and audits how the evaluated graph is wired. Whenever the evaluator creates a node, it hands the checker the node's identifier and value, together with the number of times that node will later be used as an operand. Whenever an instruction reads a node as an operand, the checker finds the stored node, confirms that the value presented matches the recorded one, and takes one use away from its count. When the run finishes, the checker walks its table and reports whether every node was used exactly as often as its producer declared.

Each run is bound to a context value and a clock tag. Both are latched when the run starts, and every request must carry them. Requests with another key never match a stored node. Storage is a table of exact per-node counters indexed by identifier, with one valid bit per entry. The valid bits are dropped in a single cycle when a new run starts. A row that loads variables inserts two nodes in one cycle on the two insert lanes. A row that evaluates an instruction consumes two operands on the two consume lanes and inserts one result.

The controller has four states. IDLE is left only by a start. RUN accepts requests and moves to SCAN on a finish request. SCAN visits one table entry per cycle and moves to DONE after the last entry. DONE holds the result until the next start. A start request in any state moves to RUN (the transition is named *restart*). The other transitions are *finish* (RUN to SCAN) and *scan_end* (SCAN to DONE).

Top module: `fanout_balance_checker`

## Requirements
- R1: After reset, `done` and `pass` are 0.
- R2: In RUN, an insert lane whose context and tag match the run key and whose identifier is not yet valid records the identifier, value and multiplicity. An insert that targets an identifier already valid in this run, or that carries a wrong key, sets a sticky error.
- R3: Both insert lanes may each record a node in the same cycle. If both lanes name the same identifier in one cycle, lane 0 is recorded and lane 1 sets the sticky error.
- R4: A consume lane with a matching key, a valid identifier, an equal value and a count of at least 1 decrements that node's count by exactly 1. A run where every count reaches zero with no error finishes with `pass`=1. This holds for identifiers 0 and 2^ID_W-1 and for the largest multiplicity 2^CNT_W-1.
- R5: A consume lane whose identifier is not valid, whose value differs from the stored value, or whose node count is already 0 sets a sticky error. The error persists until the next start and forces `pass`=0.
- R6: A consume lane whose context or tag differs from the latched run key is treated as an absent node and sets the sticky error, even when the identifier and value would otherwise match.
- R7: When both consume lanes are enabled with the same identifier in one cycle, the node needs at least 2 remaining uses. The count is then decremented by 2. Otherwise the error is set and the count is left unchanged.
- R8: A node whose count has not reached 0 at finish makes `pass`=0. A node inserted with multiplicity 0 and never used does not affect `pass`.
- R9: A start request latches a new run key, invalidates every table entry, clears the error, and drives `done` and `pass` to 0 in the next cycle. Nodes from an earlier run can neither be consumed nor cause a duplicate.
- R10: `done` rises exactly 2^ID_W clock edges after the edge that samples `fin_req` in RUN. `done` and `pass` then hold until the next start, and `pass` is never 1 while `done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_start | input | 1 | Begin a new run (restart from any state) |
| run_ctx | input | CTX_W | Context for the new run |
| run_tag | input | TAG_W | Clock tag for the new run |
| ins_en | input | 2 | Insert lane enables |
| ins_ctx | input | CTX_W | Context carried by this cycle's inserts |
| ins_tag | input | TAG_W | Clock tag carried by this cycle's inserts |
| ins_id | input | 2×ID_W | Identifier per insert lane |
| ins_val | input | 2×VAL_W | Node value per insert lane |
| ins_mult | input | 2×CNT_W | Declared fan-out per insert lane |
| con_en | input | 2 | Consume lane enables |
| con_ctx | input | CTX_W | Context carried by this cycle's consumes |
| con_tag | input | TAG_W | Clock tag carried by this cycle's consumes |
| con_id | input | 2×ID_W | Identifier per consume lane |
| con_val | input | 2×VAL_W | Operand value per consume lane |
| fin_req | input | 1 | Request end-of-run balance scan |
| done | output | 1 | Result valid (DONE state) |
| pass | output | 1 | Balanced and error-free run |

## Verification
The bench builds the block with ID_W=4, CNT_W=4, VAL_W=16 and 8-bit context and tag. This gives a 16-entry table, so the scan latency of exactly 16 edges can be counted directly. Both edge identifiers, 0 and 15, fall within a short run. A 4-bit counter allows a multiplicity of 15, which the bench drains completely through seven paired same-node consumes and one single consume. At this size, a restart that reuses identifiers from an abandoned run, and a paired consume against a count of 1, each take only a few cycles to set up.

// File: rtl/fob_pkg.sv
package fob_pkg;
    localparam int NLANE = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_SCAN = 2'd2,
        ST_DONE = 2'd3
    } fob_state_t;
endpackage

// File: rtl/fob_table.sv
module fob_table #(
    parameter int ID_W  = 4,
    parameter int VAL_W = 16,
    parameter int CNT_W = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              clr,
    input  logic [1:0]                        wr_en,
    input  logic [1:0][ID_W-1:0]              wr_id,
    input  logic [1:0][VAL_W-1:0]             wr_val,
    input  logic [1:0][CNT_W-1:0]             wr_cnt,
    input  logic [1:0]                        dec_en,
    input  logic [1:0][ID_W-1:0]              dec_id,
    input  logic [1:0]                        dec_amt0,
    output logic [(1<<ID_W)-1:0]              vld_q,
    output logic [(1<<ID_W)-1:0][VAL_W-1:0]   val_q,
    output logic [(1<<ID_W)-1:0][CNT_W-1:0]   cnt_q
);
    localparam int DEPTH = 1 << ID_W;

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        logic hit_w0, hit_w1;
        logic [CNT_W-1:0] dsum;

        assign hit_w0 = wr_en[0] && (wr_id[0] == ID_W'(e));
        assign hit_w1 = wr_en[1] && (wr_id[1] == ID_W'(e));
        assign dsum   = ((dec_en[0] && (dec_id[0] == ID_W'(e))) ? CNT_W'(dec_amt0) : '0)
                      + ((dec_en[1] && (dec_id[1] == ID_W'(e))) ? CNT_W'(1)        : '0);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld_q[e] <= 1'b0;
                val_q[e] <= '0;
                cnt_q[e] <= '0;
            end else if (clr) begin
                vld_q[e] <= 1'b0;
                cnt_q[e] <= '0;
            end else if (hit_w0) begin
                vld_q[e] <= 1'b1;
                val_q[e] <= wr_val[0];
                cnt_q[e] <= wr_cnt[0];
            end else if (hit_w1) begin
                vld_q[e] <= 1'b1;
                val_q[e] <= wr_val[1];
                cnt_q[e] <= wr_cnt[1];
            end else begin
                cnt_q[e] <= cnt_q[e] - dsum;
            end
        end
    end
endmodule

// File: rtl/fob_lane.sv
module fob_lane #(
    parameter int VAL_W = 16,
    parameter int CNT_W = 4
) (
    input  logic             en,
    input  logic             key_ok,
    input  logic             ent_vld,
    input  logic [VAL_W-1:0] ent_val,
    input  logic [CNT_W-1:0] ent_cnt,
    input  logic [VAL_W-1:0] req_val,
    input  logic [1:0]       need,
    output logic             ok,
    output logic             fault
);
    logic match;

    always_comb begin
        match = key_ok && ent_vld && (ent_val == req_val) && (ent_cnt >= CNT_W'(need));
        ok    = en && match;
        fault = en && !match;
    end
endmodule

// File: rtl/fob_ctrl.sv
module fob_ctrl
    import fob_pkg::*;
#(
    parameter int ID_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            fin,
    input  logic            err_in,
    input  logic            ent_bad,
    output logic            act,
    output logic            clr,
    output logic [ID_W-1:0] scan_idx,
    output logic            done,
    output logic            pass,
    output logic            err_q,
    output fob_state_t      state
);
    fob_state_t state_q, state_d;
    logic [ID_W-1:0] idx_q;
    logic bad_q, pass_q, last;

    assign last = (idx_q == {ID_W{1'b1}});

    always_comb begin
        state_d = state_q;
        if (start) begin
            state_d = ST_RUN;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_RUN:  if (fin)  state_d = ST_SCAN;
                ST_SCAN: if (last) state_d = ST_DONE;
                ST_DONE: state_d = ST_DONE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            err_q  <= 1'b0;
            bad_q  <= 1'b0;
            pass_q <= 1'b0;
        end else if (start) begin
            idx_q  <= '0;
            err_q  <= 1'b0;
            bad_q  <= 1'b0;
            pass_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_RUN: begin
                    if (err_in) err_q <= 1'b1;
                    if (fin) begin
                        idx_q  <= '0;
                        bad_q  <= 1'b0;
                        pass_q <= 1'b0;
                    end
                end
                ST_SCAN: begin
                    if (ent_bad) bad_q <= 1'b1;
                    idx_q <= idx_q + 1'b1;
                    if (last) pass_q <= !err_q && !bad_q && !ent_bad;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        act      = (state_q == ST_RUN) && !start;
        clr      = start;
        scan_idx = idx_q;
        done     = (state_q == ST_DONE);
        pass     = pass_q;
        state    = state_q;
    end
endmodule

// File: rtl/fanout_balance_checker.sv
module fanout_balance_checker
    import fob_pkg::*;
#(
    parameter int ID_W  = 4,
    parameter int VAL_W = 16,
    parameter int CNT_W = 4,
    parameter int CTX_W = 8,
    parameter int TAG_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        run_start,
    input  logic [CTX_W-1:0]            run_ctx,
    input  logic [TAG_W-1:0]            run_tag,
    input  logic [1:0]                  ins_en,
    input  logic [CTX_W-1:0]            ins_ctx,
    input  logic [TAG_W-1:0]            ins_tag,
    input  logic [1:0][ID_W-1:0]        ins_id,
    input  logic [1:0][VAL_W-1:0]       ins_val,
    input  logic [1:0][CNT_W-1:0]       ins_mult,
    input  logic [1:0]                  con_en,
    input  logic [CTX_W-1:0]            con_ctx,
    input  logic [TAG_W-1:0]            con_tag,
    input  logic [1:0][ID_W-1:0]        con_id,
    input  logic [1:0][VAL_W-1:0]       con_val,
    input  logic                        fin_req,
    output logic                        done,
    output logic                        pass
);
    localparam int DEPTH = 1 << ID_W;

    logic [CTX_W-1:0] key_ctx;
    logic [TAG_W-1:0] key_tag;
    logic act, clr, err_q, ent_bad, err_in;
    logic [ID_W-1:0] scan_idx;
    fob_state_t state;

    logic [DEPTH-1:0]             vld_q;
    logic [DEPTH-1:0][VAL_W-1:0]  val_q;
    logic [DEPTH-1:0][CNT_W-1:0]  cnt_q;

    logic ins_key_ok, con_key_ok, con_same, ins_same;
    logic [1:0] need, lane_ok, lane_fault, ins_fault, wr_en, dec_en;
    logic [1:0] dec_amt0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key_ctx <= '0;
            key_tag <= '0;
        end else if (run_start) begin
            key_ctx <= run_ctx;
            key_tag <= run_tag;
        end
    end

    assign ins_key_ok = (ins_ctx == key_ctx) && (ins_tag == key_tag);
    assign con_key_ok = (con_ctx == key_ctx) && (con_tag == key_tag);
    assign ins_same   = ins_en[0] && ins_en[1] && (ins_id[0] == ins_id[1]);
    assign con_same   = con_en[0] && con_en[1] && (con_id[0] == con_id[1]);
    assign need       = con_same ? 2'd2 : 2'd1;

    for (genvar i = 0; i < NLANE; i++) begin : g_lane
        fob_lane #(.VAL_W(VAL_W), .CNT_W(CNT_W)) u_lane (
            .en      (act && con_en[i]),
            .key_ok  (con_key_ok),
            .ent_vld (vld_q[con_id[i]]),
            .ent_val (val_q[con_id[i]]),
            .ent_cnt (cnt_q[con_id[i]]),
            .req_val (con_val[i]),
            .need    (need),
            .ok      (lane_ok[i]),
            .fault   (lane_fault[i])
        );

        assign ins_fault[i] = act && ins_en[i] &&
                              (!ins_key_ok || vld_q[ins_id[i]] || ((i == 1) && ins_same));
        assign wr_en[i]     = act && ins_en[i] && !ins_fault[i];
    end

    assign dec_en[0] = lane_ok[0] && (!con_same || lane_ok[1]);
    assign dec_en[1] = lane_ok[1] && !con_same;
    assign dec_amt0  = con_same ? 2'd2 : 2'd1;
    assign err_in    = |lane_fault || |ins_fault;
    assign ent_bad   = vld_q[scan_idx] && (cnt_q[scan_idx] != '0);

    fob_table #(.ID_W(ID_W), .VAL_W(VAL_W), .CNT_W(CNT_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .wr_en    (wr_en),
        .wr_id    (ins_id),
        .wr_val   (ins_val),
        .wr_cnt   (ins_mult),
        .dec_en   (dec_en),
        .dec_id   (con_id),
        .dec_amt0 (dec_amt0),
        .vld_q    (vld_q),
        .val_q    (val_q),
        .cnt_q    (cnt_q)
    );

    fob_ctrl #(.ID_W(ID_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (run_start),
        .fin      (fin_req),
        .err_in   (err_in),
        .ent_bad  (ent_bad),
        .act      (act),
        .clr      (clr),
        .scan_idx (scan_idx),
        .done     (done),
        .pass     (pass),
        .err_q    (err_q),
        .state    (state)
    );
endmodule

// File: rtl/fob_sva.sv
module fob_sva
    import fob_pkg::*;
#(
    parameter int CTX_W = 8,
    parameter int TAG_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run_start,
    input logic             done,
    input logic             pass,
    input logic             err_q,
    input logic             act,
    input logic [1:0]       con_en,
    input logic [CTX_W-1:0] con_ctx,
    input logic [TAG_W-1:0] con_tag,
    input logic [CTX_W-1:0] key_ctx,
    input logic [TAG_W-1:0] key_tag,
    input fob_state_t       state
);
    AST_PASS_ONLY_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        pass |-> done); // R10

    AST_DONE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !run_start) |=> done); // R10

    AST_DONE_AFTER_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(state) == ST_SCAN)); // R10

    AST_START_CLEARS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        run_start |=> (!done && !pass)); // R9

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !run_start) |=> err_q); // R5

    AST_ERR_BLOCKS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> !pass); // R5

    AST_KEY_MISMATCH_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        (act && con_en[0] && ((con_ctx != key_ctx) || (con_tag != key_tag))) |=> err_q); // R6
endmodule

bind fanout_balance_checker fob_sva #(.CTX_W(CTX_W), .TAG_W(TAG_W)) u_fob_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_start (run_start),
    .done      (done),
    .pass      (pass),
    .err_q     (err_q),
    .act       (act),
    .con_en    (con_en),
    .con_ctx   (con_ctx),
    .con_tag   (con_tag),
    .key_ctx   (key_ctx),
    .key_tag   (key_tag),
    .state     (state)
);

// File: tb/test_fanout_balance_checker.sv
`timescale 1ns/1ps
module test_fanout_balance_checker;
    localparam int ID_W  = 4;
    localparam int VAL_W = 16;
    localparam int CNT_W = 4;
    localparam int CTX_W = 8;
    localparam int TAG_W = 8;
    localparam int DEPTH = 1 << ID_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run_start = 1'b0;
    logic [CTX_W-1:0] run_ctx = '0;
    logic [TAG_W-1:0] run_tag = '0;
    logic [1:0] ins_en = '0;
    logic [CTX_W-1:0] ins_ctx = '0;
    logic [TAG_W-1:0] ins_tag = '0;
    logic [1:0][ID_W-1:0] ins_id = '0;
    logic [1:0][VAL_W-1:0] ins_val = '0;
    logic [1:0][CNT_W-1:0] ins_mult = '0;
    logic [1:0] con_en = '0;
    logic [CTX_W-1:0] con_ctx = '0;
    logic [TAG_W-1:0] con_tag = '0;
    logic [1:0][ID_W-1:0] con_id = '0;
    logic [1:0][VAL_W-1:0] con_val = '0;
    logic fin_req = 1'b0;
    logic done, pass;

    int vectors = 0;
    int fails = 0;
    logic [CTX_W-1:0] cur_ctx = '0;
    logic [TAG_W-1:0] cur_tag = '0;

    always #4 clk = ~clk;

    fanout_balance_checker #(
        .ID_W(ID_W), .VAL_W(VAL_W), .CNT_W(CNT_W), .CTX_W(CTX_W), .TAG_W(TAG_W)
    ) i_fanout_balance_checker (
        .clk(clk), .rst_n(rst_n), .run_start(run_start), .run_ctx(run_ctx), .run_tag(run_tag),
        .ins_en(ins_en), .ins_ctx(ins_ctx), .ins_tag(ins_tag), .ins_id(ins_id),
        .ins_val(ins_val), .ins_mult(ins_mult), .con_en(con_en), .con_ctx(con_ctx),
        .con_tag(con_tag), .con_id(con_id), .con_val(con_val), .fin_req(fin_req),
        .done(done), .pass(pass)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic start_run(input int c, input int t);
        run_start = 1'b1; run_ctx = CTX_W'(c); run_tag = TAG_W'(t);
        cur_ctx = CTX_W'(c); cur_tag = TAG_W'(t);
        @(negedge clk);
        run_start = 1'b0;
    endtask

    task automatic ins(input logic [1:0] en, input int id0, input int v0, input int m0,
                       input int id1, input int v1, input int m1);
        ins_en = en; ins_ctx = cur_ctx; ins_tag = cur_tag;
        ins_id[0] = ID_W'(id0); ins_val[0] = VAL_W'(v0); ins_mult[0] = CNT_W'(m0);
        ins_id[1] = ID_W'(id1); ins_val[1] = VAL_W'(v1); ins_mult[1] = CNT_W'(m1);
        @(negedge clk);
        ins_en = '0;
    endtask

    task automatic con_key(input logic [1:0] en, input int id0, input int v0,
                           input int id1, input int v1, input int c, input int t);
        con_en = en; con_ctx = CTX_W'(c); con_tag = TAG_W'(t);
        con_id[0] = ID_W'(id0); con_val[0] = VAL_W'(v0);
        con_id[1] = ID_W'(id1); con_val[1] = VAL_W'(v1);
        @(negedge clk);
        con_en = '0;
    endtask

    task automatic con(input logic [1:0] en, input int id0, input int v0, input int id1, input int v1);
        con_key(en, id0, v0, id1, v1, int'(cur_ctx), int'(cur_tag));
    endtask

    task automatic finish(input string req, input bit exp_pass);
        int n;
        fin_req = 1'b1;
        @(negedge clk);
        fin_req = 1'b0;
        n = 0;
        while (!done && n < 4 * DEPTH) begin
            chk("R10", "pass while not done", pass, 0);
            @(negedge clk);
            n++;
        end
        chk("R10", "scan latency", n, DEPTH);
        chk(req, "pass", pass, exp_pass);
    endtask

    task automatic t_reset;
        chk("R1", "done after reset", done, 0);
        chk("R1", "pass after reset", pass, 0);
    endtask

    task automatic t_balanced;
        start_run(3, 7);
        chk("R9", "done after start", done, 0);
        ins(2'b11, 5, 10, 2, 4, 3, 1);     // R3 two nodes in one cycle
        ins(2'b11, 3, 0, 0, 2, 0, 0);      // R8 zero-multiplicity padding
        con(2'b11, 5, 10, 4, 3);           // R4
        ins(2'b01, 1, 13, 1, 0, 0, 0);
        con(2'b11, 5, 10, 1, 13);
        ins(2'b01, 0, 130, 0, 0, 0, 0);
        finish("R4", 1'b1);
        repeat (3) @(negedge clk);
        chk("R10", "done held", done, 1);
        chk("R10", "pass held", pass, 1);
    endtask

    task automatic t_leftover;
        start_run(4, 1);
        ins(2'b01, 7, 99, 2, 0, 0, 0);
        con(2'b01, 7, 99, 0, 0);
        finish("R8", 1'b0);
    endtask

    task automatic t_value_mismatch;
        start_run(5, 1);
        ins(2'b01, 8, 42, 1, 0, 0, 0);
        con(2'b01, 8, 43, 0, 0);
        finish("R5", 1'b0);
    endtask

    task automatic t_absent;
        start_run(5, 2);
        con(2'b10, 0, 0, 11, 0);
        finish("R5", 1'b0);
    endtask

    task automatic t_zero_count;
        start_run(5, 3);
        ins(2'b01, 9, 6, 1, 0, 0, 0);
        con(2'b01, 9, 6, 0, 0);
        con(2'b01, 9, 6, 0, 0);
        finish("R5", 1'b0);
    endtask

    task automatic t_key_mismatch;
        start_run(6, 6);
        ins(2'b01, 2, 77, 1, 0, 0, 0);
        con_key(2'b01, 2, 77, 0, 0, 6, 9);  // R6 wrong tag
        con(2'b01, 2, 77, 0, 0);
        finish("R6", 1'b0);
    endtask

    task automatic t_pair_ok;
        start_run(7, 1);
        ins(2'b01, 12, 500, 2, 0, 0, 0);
        con(2'b11, 12, 500, 12, 500);      // R7 decrement by two
        finish("R7", 1'b1);
    endtask

    task automatic t_pair_short;
        start_run(7, 2);
        ins(2'b01, 12, 500, 1, 0, 0, 0);
        con(2'b11, 12, 500, 12, 500);
        finish("R7", 1'b0);
    endtask

    task automatic t_dup;
        start_run(8, 1);
        ins(2'b01, 6, 1, 0, 0, 0, 0);
        ins(2'b01, 6, 1, 0, 0, 0, 0);      // R2 duplicate across cycles
        finish("R2", 1'b0);
        start_run(8, 2);
        ins(2'b11, 6, 1, 0, 6, 1, 0);      // R3 same id on both lanes
        finish("R3", 1'b0);
    endtask

    task automatic t_restart;
        start_run(9, 1);
        ins(2'b01, 5, 21, 1, 0, 0, 0);
        start_run(10, 1);                  // R9 abandon and restart
        ins(2'b01, 5, 22, 1, 0, 0, 0);
        con(2'b01, 5, 22, 0, 0);
        finish("R9", 1'b1);
        start_run(11, 1);
        con(2'b01, 5, 22, 0, 0);
        finish("R9", 1'b0);
    endtask

    task automatic t_extremes;
        start_run(12, 4);
        ins(2'b11, DEPTH - 1, 16'hFFFF, (1 << CNT_W) - 1, 0, 0, 0);
        for (int k = 0; k < 7; k++) con(2'b11, DEPTH - 1, 16'hFFFF, DEPTH - 1, 16'hFFFF);
        con(2'b01, DEPTH - 1, 16'hFFFF, 0, 0);
        finish("R4", 1'b1);
    endtask

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog: got 0 expected 1");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_balanced;
        t_leftover;
        t_value_mismatch;
        t_absent;
        t_zero_count;
        t_key_mismatch;
        t_pair_ok;
        t_pair_short;
        t_dup;
        t_restart;
        t_extremes;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule